// File: doc/BRIEF.md
# VLIW Execution Slot Assigner

This block places the instructions of one decoded VLIW packet onto four execution slots, numbered 3 down to 0. Each instruction arrives in encoding order with a four-bit mask of the slots it may use, plus three flags: memory-like, duplex half, and loop-end pseudo-instruction. The block returns a two-bit slot for every instruction and a flag that marks the packet as illegal.

The placement runs in a fixed order. First a greedy count-down pass assigns a slot to each instruction. A memory fix-up pass follows, then a duplex fix-up pass, then a rule that stops slot 1 from being occupied while slot 0 is empty. A final uniqueness check runs last. All passes are combinational. The result is captured in one output register stage behind a valid/ready handshake, so a packet that is accepted on one clock edge appears at the outputs after that edge.

The count input sets how many entries are live. Entries at or above the count have no effect.

Top module: `ssa_slot_assigner`

## Requirements
- R1: A candidate slot starts at 3. Instructions are taken in index order, and each one receives the highest slot that is no greater than the candidate and whose bit is set in its mask. Mask bit s allows slot s, and instruction i uses mask bits [4i+3:4i].
- R2: After each assignment the candidate becomes the assigned slot minus one. When the assigned slot is 0, the candidate stays at 0, so later instructions compete for slot 0.
- R3: After the count-down, scan from the highest live index downwards. The first memory-like instruction met is placed in slot 0, and every memory-like instruction with a lower index is placed in slot 1.
- R4: After the memory pass, the same backward rule is applied to duplex halves. The highest-index duplex half goes to slot 0, the others go to slot 1, and this pass overrides the memory pass.
- R5: If no live non-loop-end instruction sits in slot 0, the lowest-index live instruction in slot 1 is moved to slot 0.
- R6: Loop-end instructions may share slot 0 with another instruction. They do not count as occupying slot 0 for R5, and they are left out of the uniqueness check.
- R7: If two live non-loop-end instructions end in the same slot, out_invalid is 1. Otherwise, with no underflow, it is 0.
- R8: If an instruction finds no allowed slot at or below the candidate, it is given slot 0, the candidate becomes 0, and out_invalid is 1.
- R9: Entries with index at or above in_count do not affect any pass, and their slot fields read 0. Slot i occupies out_slot bits [2i+1:2i].
- R10: A packet is accepted when in_valid and in_ready are both high at a clock edge, and the result is held with out_valid high from that edge onward. in_ready is high whenever out_valid is low or out_ready is high. A stalled result stays unchanged.
- R11: While rst_n is low, out_valid, out_slot and out_invalid are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Packet offered |
| in_ready | output | 1 | Packet can be taken this cycle |
| in_count | input | $clog2(N+1) | Number of live instructions |
| in_mask | input | 4*N | Allowed-slot mask per instruction |
| in_mem | input | N | Memory-like flag per instruction |
| in_duplex | input | N | Duplex-half flag per instruction |
| in_loopend | input | N | Loop-end pseudo-instruction flag |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Consumer takes the result |
| out_slot | output | 2*N | Assigned slot per instruction |
| out_invalid | output | 1 | Packet slot assignment is illegal |

## Verification
Several of the passes can act on the same packet. The cases that matter most are those where a later pass undoes an earlier one:
- A memory-like instruction is also a duplex half, so the memory pass and the duplex pass both move it.
- A loop-end instruction lands in slot 0 in the same packet where the slot-1 rule fires.

The stimulus table builds these overlaps on purpose. Each one is judged against a slot vector worked out by hand from the pass order.

On the handshake side, a new packet is offered while the previous result is still stalled. The check confirms that the held slots do not move, and that a packet accepted in the same cycle a result drains replaces it with no bubble.

// File: rtl/ssa_pkg.sv
package ssa_pkg;
  localparam int NUM_SLOTS = 4;
  localparam int SLOT_W    = $clog2(NUM_SLOTS);
  typedef logic [SLOT_W-1:0] slot_t;
endpackage

// File: rtl/ssa_countdown.sv
// Greedy pass: walk instructions in index order with a falling candidate slot.
module ssa_countdown
  import ssa_pkg::*;
#(
  parameter int N = 6
) (
  input  logic [N-1:0]           active_i,
  input  logic [N*NUM_SLOTS-1:0] mask_i,
  output logic [N*SLOT_W-1:0]    slot_o,
  output logic                   underflow_o
);
  always_comb begin
    slot_t cand;
    slot_t pick;
    logic  found;
    cand        = slot_t'(NUM_SLOTS - 1);
    slot_o      = '0;
    underflow_o = 1'b0;
    for (int i = 0; i < N; i++) begin
      pick  = '0;
      found = 1'b0;
      if (active_i[i]) begin
        // highest allowed slot not above the candidate wins
        for (int s = 0; s < NUM_SLOTS; s++) begin
          if ((slot_t'(s) <= cand) && mask_i[i*NUM_SLOTS+s]) begin
            pick  = slot_t'(s);
            found = 1'b1;
          end
        end
        if (!found) underflow_o = 1'b1;
        slot_o[i*SLOT_W +: SLOT_W] = pick;
        cand = (pick == '0) ? '0 : pick - slot_t'(1);
      end
    end
  end
endmodule

// File: rtl/ssa_pair_fix.sv
// Backward pass: the last selected instruction goes to slot 0, earlier ones to slot 1.
module ssa_pair_fix
  import ssa_pkg::*;
#(
  parameter int N = 6
) (
  input  logic [N-1:0]        sel_i,
  input  logic [N*SLOT_W-1:0] slot_i,
  output logic [N*SLOT_W-1:0] slot_o
);
  always_comb begin
    logic seen;
    seen   = 1'b0;
    slot_o = slot_i;
    for (int i = N - 1; i >= 0; i--) begin
      if (sel_i[i]) begin
        slot_o[i*SLOT_W +: SLOT_W] = seen ? slot_t'(1) : slot_t'(0);
        seen = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ssa_lone_fix.sv
// Slot 1 may not be used while slot 0 has no real occupant.
module ssa_lone_fix
  import ssa_pkg::*;
#(
  parameter int N = 6
) (
  input  logic [N-1:0]        active_i,
  input  logic [N-1:0]        loopend_i,
  input  logic [N*SLOT_W-1:0] slot_i,
  output logic [N*SLOT_W-1:0] slot_o
);
  always_comb begin
    logic zero_taken;
    logic move_pending;
    zero_taken = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (active_i[i] && !loopend_i[i] && (slot_i[i*SLOT_W +: SLOT_W] == slot_t'(0)))
        zero_taken = 1'b1;
    end
    move_pending = !zero_taken;
    slot_o       = slot_i;
    // lowest-index holder of slot 1 is the one moved
    for (int i = 0; i < N; i++) begin
      if (move_pending && active_i[i] && (slot_i[i*SLOT_W +: SLOT_W] == slot_t'(1))) begin
        slot_o[i*SLOT_W +: SLOT_W] = slot_t'(0);
        move_pending = 1'b0;
      end
    end
  end
endmodule

// File: rtl/ssa_unique.sv
// Detects two real instructions sharing one slot; loop-end entries are exempt.
module ssa_unique
  import ssa_pkg::*;
#(
  parameter int N = 6
) (
  input  logic [N-1:0]        active_i,
  input  logic [N-1:0]        loopend_i,
  input  logic [N*SLOT_W-1:0] slot_i,
  output logic                clash_o
);
  always_comb begin
    logic [NUM_SLOTS-1:0] used;
    used    = '0;
    clash_o = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (active_i[i] && !loopend_i[i]) begin
        if (used[slot_i[i*SLOT_W +: SLOT_W]]) clash_o = 1'b1;
        used[slot_i[i*SLOT_W +: SLOT_W]] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ssa_slot_assigner.sv
module ssa_slot_assigner
  import ssa_pkg::*;
#(
  parameter int N     = 6,
  localparam int CNT_W = $clog2(N + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [CNT_W-1:0]       in_count,
  input  logic [N*NUM_SLOTS-1:0] in_mask,
  input  logic [N-1:0]           in_mem,
  input  logic [N-1:0]           in_duplex,
  input  logic [N-1:0]           in_loopend,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [N*SLOT_W-1:0]    out_slot,
  output logic                   out_invalid
);
  logic [N-1:0]        active;
  logic [N*SLOT_W-1:0] greedy_slot, mem_slot, dup_slot, final_slot;
  logic                underflow, clash;

  // live-entry decode
  for (genvar g = 0; g < N; g++) begin : g_active
    assign active[g] = (CNT_W'(g) < in_count);
  end

  ssa_countdown #(.N(N)) u_countdown (
    .active_i    (active),
    .mask_i      (in_mask),
    .slot_o      (greedy_slot),
    .underflow_o (underflow)
  );

  ssa_pair_fix #(.N(N)) u_mem_fix (
    .sel_i  (active & in_mem),
    .slot_i (greedy_slot),
    .slot_o (mem_slot)
  );

  ssa_pair_fix #(.N(N)) u_dup_fix (
    .sel_i  (active & in_duplex),
    .slot_i (mem_slot),
    .slot_o (dup_slot)
  );

  ssa_lone_fix #(.N(N)) u_lone_fix (
    .active_i  (active),
    .loopend_i (in_loopend),
    .slot_i    (dup_slot),
    .slot_o    (final_slot)
  );

  ssa_unique #(.N(N)) u_unique (
    .active_i  (active),
    .loopend_i (in_loopend),
    .slot_i    (final_slot),
    .clash_o   (clash)
  );

  // handshake and output stage
  logic                valid_q, valid_d, load;
  logic [N*SLOT_W-1:0] slot_q;
  logic                inv_q;

  assign in_ready = !valid_q || out_ready;
  assign load     = in_valid && in_ready;

  always_comb begin
    if (load)           valid_d = 1'b1;
    else if (out_ready) valid_d = 1'b0;
    else                valid_d = valid_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      inv_q  <= 1'b0;
    end else if (load) begin
      slot_q <= final_slot;
      inv_q  <= underflow || clash;
    end
  end

  assign out_valid   = valid_q;
  assign out_slot    = slot_q;
  assign out_invalid = inv_q;
endmodule

// File: rtl/ssa_slot_assigner_chk.sv
module ssa_slot_assigner_chk
  import ssa_pkg::*;
#(
  parameter int N     = 6,
  localparam int CNT_W = $clog2(N + 1)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic [CNT_W-1:0]    in_count,
  input logic [N-1:0]        in_loopend,
  input logic                out_valid,
  input logic                out_ready,
  input logic [N*SLOT_W-1:0] out_slot,
  input logic                out_invalid
);
  logic [CNT_W-1:0] cnt_q;
  logic [N-1:0]     le_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      le_q  <= '0;
    end else if (in_valid && in_ready) begin
      cnt_q <= in_count;
      le_q  <= in_loopend;
    end
  end

  logic tail_set, dup_seen;
  always_comb begin
    logic [NUM_SLOTS-1:0] used;
    used     = '0;
    tail_set = 1'b0;
    dup_seen = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (CNT_W'(i) >= cnt_q) begin
        if (out_slot[i*SLOT_W +: SLOT_W] != '0) tail_set = 1'b1;
      end else if (!le_q[i]) begin
        if (used[out_slot[i*SLOT_W +: SLOT_W]]) dup_seen = 1'b1;
        used[out_slot[i*SLOT_W +: SLOT_W]] = 1'b1;
      end
    end
  end

  // R10
  accept_then_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_slot) && $stable(out_invalid));

  // R10
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid && !(in_valid && in_ready) |=> !out_valid);

  // R9
  tail_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !tail_set);

  // R7
  legal_unique_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_invalid |-> !dup_seen);
endmodule

bind ssa_slot_assigner ssa_slot_assigner_chk #(.N(N)) u_chk (.*);

// File: tb/ssa_slot_assigner_test.sv
`timescale 1ns/1ps
module ssa_slot_assigner_test;
  localparam int N = 4;
  localparam int CNT_W = $clog2(N + 1);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rst_n, in_valid, in_ready, out_valid, out_ready, out_invalid;
  logic [CNT_W-1:0] in_count;
  logic [4*N-1:0]   in_mask;
  logic [N-1:0]     in_mem, in_duplex, in_loopend;
  logic [2*N-1:0]   out_slot;

  ssa_slot_assigner #(.N(N)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_count(in_count), .in_mask(in_mask), .in_mem(in_mem), .in_duplex(in_duplex),
    .in_loopend(in_loopend), .out_valid(out_valid), .out_ready(out_ready),
    .out_slot(out_slot), .out_invalid(out_invalid)
  );

  // {req[4], count[3], mask[16], mem[4], dup[4], loopend[4], slots[8], invalid[1]}
  localparam int NV = 13;
  localparam logic [43:0] VEC [NV] = '{
    {4'd1, 3'd4, 16'hFFFF, 4'b0000, 4'b0000, 4'b0000, 8'h1B, 1'b0}, // R1 full fall 3,2,1,0
    {4'd2, 3'd3, 16'h0FF3, 4'b0000, 4'b0000, 4'b0000, 8'h01, 1'b1}, // R2 candidate pinned at 0
    {4'd8, 3'd2, 16'h008F, 4'b0000, 4'b0000, 4'b0000, 8'h03, 1'b1}, // R8 no slot left
    {4'd3, 3'd3, 16'h0F4F, 4'b0101, 4'b0000, 4'b0000, 8'h09, 1'b0}, // R3 memory pair
    {4'd4, 3'd2, 16'h00FF, 4'b0000, 4'b0011, 4'b0000, 8'h01, 1'b0}, // R4 duplex pair
    {4'd4, 3'd3, 16'h0FFF, 4'b0010, 4'b0110, 4'b0000, 8'h07, 1'b0}, // R4 duplex after memory
    {4'd5, 3'd2, 16'h0028, 4'b0000, 4'b0000, 4'b0000, 8'h03, 1'b0}, // R5 lone slot 1 moves
    {4'd6, 3'd3, 16'h01FF, 4'b0000, 4'b0000, 4'b0100, 8'h0B, 1'b0}, // R6 loop-end alone in 0
    {4'd6, 3'd4, 16'h11FF, 4'b0000, 4'b0000, 4'b1000, 8'h0B, 1'b0}, // R6 loop-end shares 0
    {4'd6, 3'd3, 16'h0128, 4'b0000, 4'b0000, 4'b0100, 8'h03, 1'b0}, // R6 with R5 move
    {4'd9, 3'd1, 16'hFFFF, 4'b1110, 4'b0100, 4'b0000, 8'h03, 1'b0}, // R9 flags past count
    {4'd9, 3'd0, 16'hFFFF, 4'b1111, 4'b0000, 4'b0000, 8'h00, 1'b0}, // R9 empty packet
    {4'd7, 3'd2, 16'h0011, 4'b0000, 4'b0000, 4'b0000, 8'h00, 1'b1}  // R7 clash in slot 0
  };

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [43:0] v);
    in_count   = v[39:37];
    in_mask    = v[36:21];
    in_mem     = v[20:17];
    in_duplex  = v[16:13];
    in_loopend = v[12:9];
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R10 watchdog actual=%0h expected=%0h", 0, 1);
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    drive(VEC[0]);
    repeat (3) @(negedge clk);
    // R11 reset state
    check(out_valid == 1'b0, "R11", "out_valid in reset", 32'(out_valid), 0);
    check(out_slot == '0, "R11", "out_slot in reset", 32'(out_slot), 0);
    check(out_invalid == 1'b0, "R11", "out_invalid in reset", 32'(out_invalid), 0);
    check(in_ready == 1'b1, "R10", "in_ready while empty", 32'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      drive(VEC[k]);
      in_valid = 1'b1; out_ready = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check(out_valid == 1'b1, $sformatf("R%0d", VEC[k][43:40]),
            $sformatf("vec %0d valid", k), 32'(out_valid), 1);
      check(out_slot == VEC[k][8:1], $sformatf("R%0d", VEC[k][43:40]),
            $sformatf("vec %0d slots", k), 32'(out_slot), 32'(VEC[k][8:1]));
      check(out_invalid == VEC[k][0], $sformatf("R%0d", VEC[k][43:40]),
            $sformatf("vec %0d invalid", k), 32'(out_invalid), 32'(VEC[k][0]));
    end

    // R10 stall: result held, new offer refused
    @(negedge clk);
    drive(VEC[3]); in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    drive(VEC[0]);
    check(in_ready == 1'b0, "R10", "in_ready while stalled", 32'(in_ready), 0);
    repeat (3) @(negedge clk);
    check(out_valid == 1'b1, "R10", "valid held", 32'(out_valid), 1);
    check(out_slot == 8'h09, "R10", "slots held under stall", 32'(out_slot), 32'h09);
    // R10 drain and accept in the same cycle
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1, "R10", "back-to-back valid", 32'(out_valid), 1);
    check(out_slot == 8'h1B, "R10", "replacement slots", 32'(out_slot), 32'h1B);
    @(negedge clk);
    check(out_valid == 1'b0, "R10", "drained", 32'(out_valid), 0);

    // R11 reset in mid-flight clears the result
    drive(VEC[0]); in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    check(out_valid == 1'b0 && out_slot == '0, "R11", "async clear",
          32'({out_valid, out_slot}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    finish_run();
  end
endmodule